// File: doc/BRIEF.md
# Multichannel SPI Channel Controller

This block is a memory-mapped controller for several SPI chip-select channels sharing one serial bus. Each channel carries a configuration word, a three-flag status word, an enable bit, a transmit data word and a receive data word. Software talks to it through a 32-bit register bus. Writing transmit data or reading receive data triggers a transfer attempt. The attempt goes ahead only when the channel is enabled and its transmit-empty and receive-full flags, read together with the channel's direction mode, allow an exchange.

A word that is allowed to go waits for the one shared shift engine. The engine serves waiting channels lowest index first. It shifts the programmed number of bits MSB-first on a divided serial clock and holds that channel's chip select low for the whole word. When a module-wide single-channel bit is set, a channel without its force bit completes the handshake at once, without touching the wire. Per-channel DMA request lines follow the flags, so a DMA engine can refill or drain a channel without software. A per-channel error line flags an illegal configuration.

Top module: `spi_mc_top`

## Requirements
- R1: After reset every channel reads configuration 0x060000, status 0x2 and control 0. The module control register reads 0, all chip selects are high, and no DMA request is raised.
- R2: Channel k has its registers at 0x2C + 0x14*k: configuration at +0x0, status at +0x4, control at +0x8, transmit at +0xC and receive at +0x10. Module control sits at 0x28, with bit 0 as the single-channel bit. A configuration write keeps only bits 22:0. Writes to status and receive change nothing.
- R3: Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. Configuration bits 13:12 select the mode: 0 is both directions, 1 is receive-only, 2 is transmit-only. A transmit write stores the data, clears transmit-empty and attempts a transfer. The attempt stalls on transmit-empty unless the mode is receive-only.
- R4: A receive read returns the stored word, clears receive-full and attempts a transfer. The attempt stalls while receive-full is set, unless the mode is transmit-only or the turbo bit (configuration bit 19) is set.
- R5: While enable (control bit 0) is clear, no attempt starts anything. Setting enable from clear attempts a transfer. Any other control write only stores the bit.
- R6: On completion the transmit word becomes 0, and end-of-transfer and transmit-empty are set. Receive-full is also set unless the mode is transmit-only.
- R7: The serial wire is used only when single-channel is clear or force (configuration bit 20) is set. Otherwise the attempt completes in the same cycle, with no chip select and the receive word unchanged.
- R8: A wire transfer sends (configuration bits 11:7)+1 bits, MSB first. MOSI changes while SCLK is low and MISO is sampled on the rising SCLK edge. Each SCLK phase lasts CLK_DIV cycles. Exactly one chip select is low, and it stays low for the whole word. The received bits land right-aligned in the receive word.
- R9: Transmit DMA request = enable AND configuration bit 14 AND transmit-empty AND mode not receive-only. Receive DMA request = enable AND configuration bit 15 AND receive-full AND mode not transmit-only.
- R10: While a channel's word is waiting or shifting, further attempts on it are dropped. Its flags change only at the edge where the last bit finishes. Waiting channels are served lowest index first.
- R11: A channel's error line is high while its word-length field is below 3 or its mode is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CH | Active-low chip selects |
| dma_tx_req | output | NUM_CH | Per-channel transmit DMA request |
| dma_rx_req | output | NUM_CH | Per-channel receive DMA request |
| cfg_err | output | NUM_CH | Per-channel illegal-configuration flag |

## Verification
Read data is combinational in the access cycle. Every register side effect, including an attempt that completes without the wire, shows at the edge that ends that access. A wire transfer of n bits is granted one edge after the triggering access and completes 2*CLK_DIV*n edges after the grant. The bench therefore reads status once just before that completion edge, expecting the flags unchanged, and once just after. Random transfers wait that computed count plus a margin. The DMA and error lines are sampled half a cycle after the access that changes them.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;
  localparam int CFG_W    = 23;
  localparam int F_WL_LO  = 7;
  localparam int F_TRM_LO = 12;
  localparam int F_DMA_TX = 14;
  localparam int F_DMA_RX = 15;
  localparam int F_TURBO  = 19;
  localparam int F_FORCE  = 20;
  localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

  typedef enum logic [1:0] {TRM_BOTH = 2'd0, TRM_RX = 2'd1, TRM_TX = 2'd2, TRM_BAD = 2'd3} trm_e;
  typedef enum logic [1:0] {CH_IDLE = 2'd0, CH_PEND = 2'd1, CH_BUSY = 2'd2} ch_st_e;
endpackage

// File: rtl/spi_mc_chan.sv
module spi_mc_chan
  import spi_mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_ctl,
  input  logic              wr_tx,
  input  logic              rd_rx,
  input  logic [31:0]       wdata,
  input  logic              single_i,
  input  logic              grant_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [2:0]        sts_o,
  output logic              en_o,
  output logic [DATA_W-1:0] tx_o,
  output logic [DATA_W-1:0] rx_o,
  output logic [4:0]        wl_o,
  output logic              pend_o,
  output logic              busy_o,
  output logic              dma_tx_o,
  output logic              dma_rx_o,
  output logic              err_o
);
  logic [CFG_W-1:0]  cfg_q, cfg_n;
  logic              en_q, en_n, txs_q, txs_n, rxs_q, rxs_n, eot_q, eot_n;
  logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n;
  ch_st_e            st_q, st_n;
  trm_e              mode_q, mode_n;
  logic              ev, stall, go;

  assign mode_q = trm_e'(cfg_q[F_TRM_LO +: 2]);

  always_comb begin
    cfg_n = cfg_q; en_n = en_q; tx_n = tx_q; rx_n = rx_q;
    txs_n = txs_q; rxs_n = rxs_q; eot_n = eot_q; st_n = st_q; ev = 1'b0;
    if (done_i) begin
      rx_n = rx_word_i; tx_n = '0; txs_n = 1'b1; eot_n = 1'b1;
      if (mode_q != TRM_TX) rxs_n = 1'b1;
      st_n = CH_IDLE;
    end else if (grant_i) begin
      st_n = CH_BUSY;
    end
    if (wr_cfg) cfg_n = wdata[CFG_W-1:0];
    if (wr_ctl) begin
      if (wdata[0] && !en_q) begin en_n = 1'b1; ev = 1'b1; end
      else en_n = wdata[0];
    end
    if (wr_tx) begin tx_n = wdata[DATA_W-1:0]; txs_n = 1'b0; ev = 1'b1; end
    if (rd_rx) begin rxs_n = 1'b0; ev = 1'b1; end
    mode_n = trm_e'(cfg_n[F_TRM_LO +: 2]);
    stall  = (rxs_n && mode_n != TRM_TX && !cfg_n[F_TURBO]) || (txs_n && mode_n != TRM_RX);
    go     = ev && en_n && !stall && st_q == CH_IDLE;
    if (go) begin
      if (!single_i || cfg_n[F_FORCE]) st_n = CH_PEND;
      else begin
        tx_n = '0; txs_n = 1'b1; eot_n = 1'b1;
        if (mode_n != TRM_TX) rxs_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST; en_q <= 1'b0; tx_q <= '0; rx_q <= '0;
      txs_q <= 1'b1; rxs_q <= 1'b0; eot_q <= 1'b0; st_q <= CH_IDLE;
    end else begin
      cfg_q <= cfg_n; en_q <= en_n; tx_q <= tx_n; rx_q <= rx_n;
      txs_q <= txs_n; rxs_q <= rxs_n; eot_q <= eot_n; st_q <= st_n;
    end
  end

  assign cfg_o    = cfg_q;
  assign sts_o    = {eot_q, txs_q, rxs_q};
  assign en_o     = en_q;
  assign tx_o     = tx_q;
  assign rx_o     = rx_q;
  assign wl_o     = cfg_q[F_WL_LO +: 5];
  assign pend_o   = (st_q == CH_PEND);
  assign busy_o   = (st_q == CH_BUSY);
  assign dma_tx_o = en_q && cfg_q[F_DMA_TX] && txs_q && mode_q != TRM_RX;
  assign dma_rx_o = en_q && cfg_q[F_DMA_RX] && rxs_q && mode_q != TRM_TX;
  assign err_o    = (cfg_q[F_WL_LO +: 5] < 5'd3) || (mode_q == TRM_BAD);

  // R6: the engine's completion pulse leaves transmit-empty and end-of-transfer set
  a_r6_done_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !wr_tx) |=> (sts_o[1] && sts_o[2]));
endmodule

// File: rtl/spi_mc_engine.sv
module spi_mc_engine #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              pend_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  tx_i,
  input  logic [NUM_CH-1:0][4:0]         wl_i,
  input  logic                           miso_i,
  output logic [NUM_CH-1:0]              grant_o,
  output logic [NUM_CH-1:0]              done_o,
  output logic [DATA_W-1:0]              rx_word_o,
  output logic                           sclk_o,
  output logic                           mosi_o,
  output logic [NUM_CH-1:0]              cs_n_o
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int LEN_W = $clog2(DATA_W) + 1;
  localparam int CNT_W = $clog2(CLK_DIV) + 1;

  logic              act_q, act_n, hi_q, hi_n;
  logic [CH_W-1:0]   ch_q, ch_n, sel;
  logic [DATA_W-1:0] sh_q, sh_n, rsh_q, rsh_n;
  logic [LEN_W-1:0]  left_q, left_n, nb;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    sel = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) if (pend_i[k]) sel = CH_W'(k);
  end

  always_comb begin
    act_n = act_q; hi_n = hi_q; ch_n = ch_q; sh_n = sh_q; rsh_n = rsh_q;
    left_n = left_q; cnt_n = cnt_q; grant_o = '0; done_o = '0;
    nb = LEN_W'(wl_i[sel]) + LEN_W'(1);
    if (!act_q && |pend_i) begin
      grant_o[sel] = 1'b1;
      act_n = 1'b1; ch_n = sel; hi_n = 1'b0; cnt_n = '0;
      sh_n = tx_i[sel] << (LEN_W'(DATA_W) - nb);
      rsh_n = '0; left_n = nb;
    end else if (act_q) begin
      if (cnt_q == CNT_W'(CLK_DIV - 1)) begin
        cnt_n = '0; hi_n = !hi_q;
        if (!hi_q) rsh_n = {rsh_q[DATA_W-2:0], miso_i};
        else begin
          sh_n = sh_q << 1; left_n = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin act_n = 1'b0; done_o[ch_q] = 1'b1; end
        end
      end else cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; hi_q <= 1'b0; ch_q <= '0; sh_q <= '0; rsh_q <= '0;
      left_q <= '0; cnt_q <= '0;
    end else begin
      act_q <= act_n; hi_q <= hi_n; ch_q <= ch_n; sh_q <= sh_n; rsh_q <= rsh_n;
      left_q <= left_n; cnt_q <= cnt_n;
    end
  end

  always_comb begin
    cs_n_o = '1;
    if (act_q) cs_n_o[ch_q] = 1'b0;
  end
  assign sclk_o    = hi_q;
  assign mosi_o    = act_q && sh_q[DATA_W-1];
  assign rx_word_o = rsh_q;

  a_r8_one_cs: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n_o));
  a_r8_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_o) |-> (!sclk_o && !mosi_o));
endmodule

// File: rtl/spi_mc_top.sv
module spi_mc_top
  import spi_mc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CH-1:0] spi_cs_n,
  output logic [NUM_CH-1:0] dma_tx_req,
  output logic [NUM_CH-1:0] dma_rx_req,
  output logic [NUM_CH-1:0] cfg_err
);
  localparam logic [7:0] MOD_ADDR = 8'h28;
  localparam int         CH_BASE  = 'h2C;
  localparam int         CH_STEP  = 'h14;

  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic wr_s, rd_s, single_q, single_n;
  assign wr_s = bus_sel && bus_wr;
  assign rd_s = bus_sel && !bus_wr;
  assign single_n = (wr_s && bus_addr == MOD_ADDR) ? bus_wdata[0] : single_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) single_q <= 1'b0;
    else        single_q <= single_n;
  end

  logic [NUM_CH-1:0][CFG_W-1:0]  cfg_w;
  logic [NUM_CH-1:0][2:0]        sts_w;
  logic [NUM_CH-1:0][DATA_W-1:0] tx_w, rx_w;
  logic [NUM_CH-1:0][4:0]        wl_w;
  logic [NUM_CH-1:0]             en_w, pend_w, busy_w, grant_w, done_w;
  logic [DATA_W-1:0]             rx_word;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [7:0] BASE = 8'(CH_BASE + k * CH_STEP);
    spi_mc_chan #(.DATA_W(DATA_W)) chan_i (
      .clk(clk), .rst_n(rst_s),
      .wr_cfg(wr_s && bus_addr == BASE),
      .wr_ctl(wr_s && bus_addr == BASE + 8'h08),
      .wr_tx (wr_s && bus_addr == BASE + 8'h0C),
      .rd_rx (rd_s && bus_addr == BASE + 8'h10),
      .wdata(bus_wdata), .single_i(single_q),
      .grant_i(grant_w[k]), .done_i(done_w[k]), .rx_word_i(rx_word),
      .cfg_o(cfg_w[k]), .sts_o(sts_w[k]), .en_o(en_w[k]), .tx_o(tx_w[k]),
      .rx_o(rx_w[k]), .wl_o(wl_w[k]), .pend_o(pend_w[k]), .busy_o(busy_w[k]),
      .dma_tx_o(dma_tx_req[k]), .dma_rx_o(dma_rx_req[k]), .err_o(cfg_err[k])
    );
    // R10: a shifting channel owns its chip select for the whole word
    a_r10_busy_holds_cs: assert property (@(posedge clk) disable iff (!rst_s)
      busy_w[k] |-> !spi_cs_n[k]);
  end

  spi_mc_engine #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) engine_i (
    .clk(clk), .rst_n(rst_s), .pend_i(pend_w), .tx_i(tx_w), .wl_i(wl_w),
    .miso_i(spi_miso), .grant_o(grant_w), .done_o(done_w), .rx_word_o(rx_word),
    .sclk_o(spi_sclk), .mosi_o(spi_mosi), .cs_n_o(spi_cs_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MOD_ADDR) bus_rdata[0] = single_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (bus_addr == 8'(CH_BASE + k * CH_STEP))        bus_rdata = 32'(cfg_w[k]);
      if (bus_addr == 8'(CH_BASE + k * CH_STEP + 'h04)) bus_rdata = 32'(sts_w[k]);
      if (bus_addr == 8'(CH_BASE + k * CH_STEP + 'h08)) bus_rdata = 32'(en_w[k]);
      if (bus_addr == 8'(CH_BASE + k * CH_STEP + 'h0C)) bus_rdata = 32'(tx_w[k]);
      if (bus_addr == 8'(CH_BASE + k * CH_STEP + 'h10)) bus_rdata = 32'(rx_w[k]);
    end
  end
endmodule

// File: tb/spi_mc_top_tb_top.sv
module spi_mc_top_tb_top;
  localparam int DIV = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n, dma_tx_req, dma_rx_req, cfg_err;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] mon_word;
  int mon_cnt;
  logic [3:0] mon_cs;

  always #2.5 clk = ~clk;
  assign spi_miso = ~spi_mosi;

  spi_mc_top #(.NUM_CH(4), .DATA_W(32), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req), .cfg_err(cfg_err));

  always @(posedge spi_sclk) begin
    mon_word = {mon_word[30:0], spi_mosi};
    mon_cnt  = mon_cnt + 1;
    mon_cs   = spi_cs_n;
  end

  function automatic logic [7:0] a_cfg(int k); return 8'(8'h2C + k * 20); endfunction
  function automatic logic [7:0] a_sts(int k); return 8'(8'h30 + k * 20); endfunction
  function automatic logic [7:0] a_ctl(int k); return 8'(8'h34 + k * 20); endfunction
  function automatic logic [7:0] a_tx(int k);  return 8'(8'h38 + k * 20); endfunction
  function automatic logic [7:0] a_rx(int k);  return 8'(8'h3C + k * 20); endfunction
  function automatic logic [31:0] mk_cfg(int n, int mode);
    return 32'(((n - 1) << 7) | (mode << 12));
  endfunction
  function automatic logic [31:0] exp_rx(logic [31:0] d, int n);
    return ~d & (32'hFFFF_FFFF >> (32 - n));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic prep(int k, logic [31:0] cfg);
    logic [31:0] dummy;
    wr(a_ctl(k), 0); wr(a_cfg(k), cfg); rd(a_rx(k), dummy); wr(a_ctl(k), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, old;
    mon_cnt = 0; mon_word = '0; mon_cs = '1;
    cyc(3); rst_n = 1'b1; cyc(5);

    // R1 reset state
    rd(a_cfg(0), v); chk("R1 cfg", v, 32'h060000);
    rd(a_sts(3), v); chk("R1 sts", v, 32'h2);
    rd(a_ctl(1), v); chk("R1 ctl", v, 0);
    rd(8'h28, v);    chk("R1 modctl", v, 0);
    chk("R1 cs", 32'(spi_cs_n), 32'hF);
    chk("R1 dma", 32'({dma_tx_req, dma_rx_req}), 0);
    chk("R11 reset err", 32'(cfg_err), 32'hF);

    // R2 masking and read-only registers, R11 error flag
    wr(a_cfg(1), 32'hFFFF_FFFF); rd(a_cfg(1), v); chk("R2 cfg mask", v, 32'h7F_FFFF);
    chk("R11 mode3", 32'(cfg_err[1]), 1);
    wr(a_cfg(1), mk_cfg(8, 0)); #1 chk("R11 ok", 32'(cfg_err[1]), 0);
    wr(a_cfg(1), mk_cfg(3, 0)); #1 chk("R11 short", 32'(cfg_err[1]), 1);
    wr(a_sts(0), 0); rd(a_sts(0), v); chk("R2 sts ro", v, 32'h2);
    wr(a_rx(0), 32'h55); rd(a_rx(0), v); chk("R2 rx ro", v, 0);

    // R5 disabled channel: no transfer until enable rises
    wr(a_cfg(0), mk_cfg(8, 0)); mon_cnt = 0;
    wr(a_tx(0), 32'hA5); cyc(40);
    chk("R5 no cs", 32'(spi_cs_n), 32'hF);
    rd(a_sts(0), v); chk("R5 sts", v, 0);
    rd(a_tx(0), v);  chk("R3 tx stored", v, 32'hA5);
    wr(a_ctl(0), 1); cyc(2 * DIV * 8 + 2);
    rd(a_sts(0), v); chk("R6 sts", v, 32'h7);
    rd(a_tx(0), v);  chk("R6 tx cleared", v, 0);
    chk("R8 mosi", mon_word & 32'hFF, 32'hA5);
    chk("R8 bits", 32'(mon_cnt), 8);
    wr(a_ctl(0), 1); rd(a_ctl(0), v); chk("R5 store", v, 1);
    rd(a_rx(0), v);  chk("R8 rx", v, exp_rx(32'hA5, 8));
    rd(a_sts(0), v); chk("R4 rxs clr", v, 32'h6);

    // R10 flags change only at the final edge; second write while busy is dropped
    mon_cnt = 0;
    wr(a_tx(0), 32'h3C); cyc(2 * DIV * 8 - 1);
    rd(a_sts(0), v); chk("R10 before end", v, 32'h4);
    rd(a_sts(0), v); chk("R10 at end", v, 32'h7);
    rd(a_rx(0), v);  chk("R10 rx", v, exp_rx(32'h3C, 8));
    mon_cnt = 0;
    wr(a_tx(0), 32'h96); cyc(4); wr(a_tx(0), 32'hFF); cyc(2 * DIV * 8 + 4);
    chk("R10 drop bits", 32'(mon_cnt), 8);
    rd(a_tx(0), v);  chk("R10 drop tx", v, 0);
    rd(a_sts(0), v); chk("R10 drop sts", v, 32'h7);

    // R4 receive-full stall, then release by reading
    wr(a_tx(0), 32'h11); cyc(40);
    rd(a_sts(0), v); chk("R4 stall", v, 32'h5);
    chk("R4 stall cs", 32'(spi_cs_n), 32'hF);
    rd(a_rx(0), v);  chk("R4 rx data", v, exp_rx(32'h96, 8));
    cyc(2 * DIV * 8 + 2);
    rd(a_sts(0), v); chk("R4 resumed", v, 32'h7);
    // R4 turbo ignores receive-full
    wr(a_cfg(0), mk_cfg(8, 0) | (1 << 19)); wr(a_tx(0), 32'h22); cyc(2 * DIV * 8 + 2);
    rd(a_rx(0), v);  chk("R4 turbo rx", v, exp_rx(32'h22, 8));

    // R6 transmit-only completion leaves receive-full clear
    prep(0, mk_cfg(8, 2)); wr(a_tx(0), 32'h81); cyc(2 * DIV * 8 + 2);
    rd(a_sts(0), v); chk("R6 txonly", v, 32'h6);

    // R3 receive-only ignores transmit-empty; R9 DMA
    wr(a_ctl(0), 0); wr(a_cfg(0), mk_cfg(8, 1) | (3 << 14));
    wr(a_ctl(0), 1); cyc(2 * DIV * 8 + 2);
    rd(a_sts(0), v); chk("R3 rxonly", v, 32'h7);
    chk("R9 rx dma", 32'(dma_rx_req[0]), 1);
    chk("R9 tx dma rxonly", 32'(dma_tx_req[0]), 0);
    rd(a_rx(0), v);  chk("R3 rxonly data", v, 32'hFF);
    chk("R9 rx dma drop", 32'(dma_rx_req[0]), 0);
    wr(a_ctl(0), 0); cyc(80);
    wr(a_cfg(2), mk_cfg(8, 0) | (1 << 14)); wr(a_ctl(2), 1);
    chk("R9 tx dma", 32'(dma_tx_req[2]), 1);
    wr(a_ctl(2), 0); chk("R9 tx dma off", 32'(dma_tx_req[2]), 0);

    // R7 single-channel without force completes off the wire
    prep(3, mk_cfg(8, 0)); rd(a_rx(3), old);
    wr(8'h28, 1); mon_cnt = 0;
    wr(a_tx(3), 32'h99);
    rd(a_sts(3), v); chk("R7 immediate", v, 32'h7);
    cyc(40);
    chk("R7 no wire", 32'(mon_cnt), 0);
    rd(a_rx(3), v); chk("R7 rx kept", v, old);
    wr(a_cfg(3), mk_cfg(8, 0) | (1 << 20));
    wr(a_tx(3), 32'h99); cyc(2 * DIV * 8 + 2);
    chk("R7 force cs", 32'(mon_cs), 32'h7);
    rd(a_rx(3), v); chk("R7 force rx", v, exp_rx(32'h99, 8));
    wr(8'h28, 0); wr(a_ctl(3), 0);

    // R10 lowest index served first
    prep(0, mk_cfg(16, 0)); prep(1, mk_cfg(8, 0)); prep(2, mk_cfg(8, 0));
    wr(a_tx(0), 32'h1234); wr(a_tx(2), 32'h0F); wr(a_tx(1), 32'hF0);
    cyc(2 * DIV * 16 - 2);
    chk("R10 order", 32'(spi_cs_n), 32'hD);
    cyc(2 * 2 * DIV * 8 + 8);
    rd(a_rx(0), v); chk("R10 ch0 rx", v, exp_rx(32'h1234, 16));
    rd(a_rx(1), v); chk("R10 ch1 rx", v, exp_rx(32'hF0, 8));
    rd(a_rx(2), v); chk("R10 ch2 rx", v, exp_rx(32'h0F, 8));
    for (int k = 0; k < 3; k++) wr(a_ctl(k), 0);

    // Random transfers, R8 word lengths and data
    void'($urandom(32'd20240611));
    for (int it = 0; it < 24; it++) begin
      int k, n;
      logic [31:0] d;
      k = int'($urandom % 4); n = 4 + int'($urandom % 29); d = $urandom;
      prep(k, mk_cfg(n, 0)); mon_cnt = 0;
      wr(a_tx(k), d); cyc(2 * DIV * n + 2);
      rd(a_sts(k), v); chk("R6 rand sts", v, 32'h7);
      rd(a_rx(k), v);  chk("R8 rand rx", v, exp_rx(d, n));
      chk("R8 rand bits", 32'(mon_cnt), 32'(n));
      chk("R8 rand msb", mon_word & (32'hFFFF_FFFF >> (32 - n)), d & (32'hFFFF_FFFF >> (32 - n)));
      chk("R8 rand cs", 32'(mon_cs), 32'(~(4'b1 << k)) & 32'hF);
      rd(a_sts(k), v); chk("R4 rand sts", v, 32'h6);
      wr(a_ctl(k), 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule